// File: doc/BRIEF.md
# Arbitrated External Bus Master

This block is the master side of a synchronous, shared external bus. A local client hands it one transaction at a time: address, direction, size, burst shape and, for writes, a 16-byte data line. The controller runs the request through four steps in a fixed order. It first asks an external arbiter for the bus. It then presents the address and transfer attributes in a one-cycle start cycle. Next it moves one or more data beats, each closed by a slave acknowledge. Finally it hands the result back to the client.

A single transfer moves one beat of 1, 2 or 4 bytes. There are three burst shapes, and each moves 16 bytes with a different beat width: four 4-byte beats, eight 2-byte beats, or sixteen 1-byte beats. The beat address steps by the beat width after every acknowledged beat. Bus timing is protected in three ways. Write data is never driven in the start cycle. The master releases the data bus after the final acknowledge. Every output stays frozen while the slave inserts wait cycles.

Top module: `ext_bus_master`

## Requirements
- R1: After a request is accepted (`req_valid` high while `req_ready` is high), `bus_req` is high from the next cycle. `bus_start` rises only in the cycle after `bus_grant` was sampled high with `bus_req` high, and `bus_start` lasts exactly one cycle.
- R2: `bus_req` is low in the start cycle and stays low for the rest of the transaction.
- R3: During the start cycle, the bus carries the request address on `bus_addr` and the attributes. `bus_read` is 1 for a read. `bus_burst` is 0 for single, 1 for 4x4-byte, 2 for 8x2-byte and 3 for 16x1-byte. `bus_size` is the beat width as log2 of bytes (0=1, 1=2, 2=4); a burst forces the size to its own beat width.
- R4: A single transfer (`req_burst`=0) makes exactly one beat, using `req_size` with the same log2 encoding. Bytes travel on the low byte lanes of the 32-bit data bus (lane i is bits 8i+7:8i), and unused lanes read as zero.
- R5: A burst makes 4, 8 or 16 beats for codes 1, 2 or 3. Each beat completes only on a cycle where `bus_ack` is sampled high. After each acknowledged beat, `bus_addr` advances by the beat width.
- R6: On writes, `bus_doe` is low in the start cycle and high from the cycle after it. During beat k, `bus_dout` lane i carries line byte k*W+i, where line byte j is `req_wdata` bits 8j+7:8j and W is the beat width. On reads, `bus_doe` stays low.
- R7: `bus_doe` is low in the cycle after the final acknowledged beat.
- R8: On reads, the lanes of `bus_din` are captured at the edge where `bus_ack` is sampled high. Beat k's lane i fills byte k*W+i of `rsp_rdata`, and bytes no beat covers are zero.
- R9: While a data beat waits for `bus_ack`, `bus_addr` and `bus_dout` stay unchanged.
- R10: `rsp_done` is high for exactly the one cycle after the final acknowledged beat. `req_ready` is high in the following cycle, and `rsp_rdata` holds its value until the next request is accepted.
- R11: `req_valid` has no effect while `req_ready` is low. No second transaction starts, so `bus_req` stays low after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Start byte address |
| req_size | input | 2 | Single-transfer width, log2 bytes |
| req_burst | input | 2 | 0 single, 1 = 4x4, 2 = 8x2, 3 = 16x1 |
| req_wdata | input | 128 | Write line, byte j at bits 8j+7:8j |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 128 | Assembled read line |
| bus_req | output | 1 | Bus request to arbiter |
| bus_grant | input | 1 | Bus grant from arbiter |
| bus_start | output | 1 | One-cycle transfer-start strobe |
| bus_addr | output | 32 | Current beat address |
| bus_read | output | 1 | Direction attribute, 1 = read |
| bus_size | output | 2 | Beat width attribute, log2 bytes |
| bus_burst | output | 2 | Burst shape attribute |
| bus_dout | output | 32 | Write data to bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 32 | Read data from bus |
| bus_ack | input | 1 | Slave transfer acknowledge |

## Verification
The assertions assume that `bus_ack` is raised only while the controller is in a data beat. They also assume that `bus_grant` is sampled only as a reply to `bus_req`, and that `req_size` never carries the unused code 3 for single transfers. The bench acts as arbiter and slave. It raises grant only after it has seen the request, raises acknowledge only in data cycles, after a random count of wait cycles, and drops both after one cycle. It draws single sizes only from 0 to 2.

// File: rtl/ebm_pkg.sv
// Package: shared state type and attribute decoding for the external bus master.
// Assumes the fixed burst shapes: code 1 = 4-byte beats, 2 = 2-byte, 3 = 1-byte.
package ebm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } ebm_state_t;

    // Beat width as log2 of bytes for a given burst code and single size.
    function automatic logic [1:0] beat_log(input logic [1:0] burst, input logic [1:0] size);
        case (burst)
            2'd1:    beat_log = 2'd2;
            2'd2:    beat_log = 2'd1;
            2'd3:    beat_log = 2'd0;
            default: beat_log = size;
        endcase
    endfunction

endpackage

// File: rtl/ebm_ctrl.sv
// Transaction sequencer: idle, bus request, address cycle, data beats, done.
// Assumes the arbiter answers bus_req with bus_grant and the slave acks only in data beats.
module ebm_ctrl
    import ebm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic bus_grant,
    input  logic bus_ack,
    input  logic last_beat,
    output logic st_idle,
    output logic st_req,
    output logic st_addr,
    output logic st_data,
    output logic st_done
);

    ebm_state_t state_q, state_d;

    // Next-state selection for the transaction phases.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept)              state_d = ST_REQ;
            ST_REQ:  if (bus_grant)           state_d = ST_ADDR;
            ST_ADDR:                          state_d = ST_DATA;
            ST_DATA: if (bus_ack && last_beat) state_d = ST_DONE;
            ST_DONE:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign st_idle = (state_q == ST_IDLE);
    assign st_req  = (state_q == ST_REQ);
    assign st_addr = (state_q == ST_ADDR);
    assign st_data = (state_q == ST_DATA);
    assign st_done = (state_q == ST_DONE);

endmodule

// File: rtl/ebm_beat.sv
// Beat counter and beat address: loads the start address, steps by beat width per ack.
// Assumes wlog and single are stable for the whole transaction.
module ebm_beat #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    localparam int BEAT_W    = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              step,
    input  logic [1:0]        wlog,
    input  logic              single,
    output logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_beat
);

    logic [BEAT_W-1:0] last_idx;

    // Final beat index for the latched shape.
    always_comb begin
        if (single) last_idx = '0;
        else        last_idx = BEAT_W'((LINE_BYTES >> wlog) - 1);
    end

    assign last_beat = (beat == last_idx);

    // Beat index and address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat     <= '0;
            cur_addr <= '0;
        end else if (load) begin
            beat     <= '0;
            cur_addr <= base_addr;
        end else if (step && !last_beat) begin
            beat     <= beat + 1'b1;
            cur_addr <= cur_addr + (ADDR_W'(1) << wlog);
        end
    end

endmodule

// File: rtl/ebm_lanes.sv
// Data lanes: selects write bytes for the current beat and assembles read beats into a line.
// Assumes bytes use the low lanes of the bus, lane i carrying beat byte i.
module ebm_lanes #(
    parameter int BUS_BYTES  = 4,
    parameter int LINE_BYTES = 16,
    localparam int BUS_W     = 8 * BUS_BYTES,
    localparam int LINE_W    = 8 * LINE_BYTES,
    localparam int BEAT_W    = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [BEAT_W-1:0] beat,
    input  logic [1:0]        wlog,
    input  logic [LINE_W-1:0] wline,
    input  logic [BUS_W-1:0]  din,
    output logic [BUS_W-1:0]  dout,
    output logic [LINE_W-1:0] rline
);

    // Write lane selection for the current beat.
    always_comb begin
        dout = '0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (i < (1 << wlog)) begin
                dout[8*i +: 8] = wline[8*((int'(beat) << wlog) + i) +: 8];
            end
        end
    end

    // Read line assembly on each acknowledged beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rline <= '0;
        end else if (capture) begin
            for (int j = 0; j < LINE_BYTES; j++) begin
                if ((j >= (int'(beat) << wlog)) && (j < ((int'(beat) << wlog) + (1 << wlog)))) begin
                    rline[8*j +: 8] <= din[8*(j - (int'(beat) << wlog)) +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/ext_bus_master.sv
// Arbitrated external bus master: runs one local request as request, start, data beats, done.
// Assumes one request at a time; req_size code 3 is not used for single transfers.
module ext_bus_master
    import ebm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 4,
    parameter int LINE_BYTES = 16,
    localparam int BUS_W     = 8 * BUS_BYTES,
    localparam int LINE_W    = 8 * LINE_BYTES,
    localparam int BEAT_W    = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_burst,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [LINE_W-1:0] rsp_rdata,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_start,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_read,
    output logic [1:0]        bus_size,
    output logic [1:0]        bus_burst,
    output logic [BUS_W-1:0]  bus_dout,
    output logic              bus_doe,
    input  logic [BUS_W-1:0]  bus_din,
    input  logic              bus_ack
);

    logic              accept;
    logic              st_idle, st_req, st_addr, st_data, st_done;
    logic              last_beat;
    logic [BEAT_W-1:0] beat;
    logic              write_q;
    logic [1:0]        wlog_q;
    logic [1:0]        burst_q;
    logic [LINE_W-1:0] wline_q;
    logic              in_data;

    assign accept  = req_valid && st_idle;
    assign in_data = st_data;

    // Request latch: direction, shape and write line held for the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            wlog_q  <= '0;
            burst_q <= '0;
            wline_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            wlog_q  <= beat_log(req_burst, req_size);
            burst_q <= req_burst;
            wline_q <= req_wdata;
        end
    end

    ebm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .bus_grant (bus_grant),
        .bus_ack   (bus_ack),
        .last_beat (last_beat),
        .st_idle   (st_idle),
        .st_req    (st_req),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_done   (st_done)
    );

    ebm_beat #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .base_addr (req_addr),
        .step      (st_data && bus_ack),
        .wlog      (wlog_q),
        .single    (burst_q == 2'd0),
        .beat      (beat),
        .cur_addr  (bus_addr),
        .last_beat (last_beat)
    );

    ebm_lanes #(
        .BUS_BYTES  (BUS_BYTES),
        .LINE_BYTES (LINE_BYTES)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (st_data && bus_ack && !write_q),
        .beat    (beat),
        .wlog    (wlog_q),
        .wline   (wline_q),
        .din     (bus_din),
        .dout    (bus_dout),
        .rline   (rsp_rdata)
    );

    assign req_ready = st_idle;
    assign bus_req   = st_req;
    assign bus_start = st_addr;
    assign bus_doe   = st_data && write_q;
    assign rsp_done  = st_done;
    assign bus_read  = !write_q;
    assign bus_size  = wlog_q;
    assign bus_burst = burst_q;

endmodule

// File: rtl/ebm_checker.sv
// Checker for the external bus master: bus phase ordering, drive rules and wait-state hold.
// Assumes bus_ack arrives only in data beats and grant only in reply to a request.
module ebm_checker #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              bus_start,
    input logic              bus_doe,
    input logic              bus_read,
    input logic              bus_ack,
    input logic              in_data,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_dout
);

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    assert_start_after_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_start) |-> $past(bus_req && bus_grant));

    assert_req_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start || in_data || rsp_done) |-> !bus_req);

    assert_no_drive_in_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> !bus_doe);

    assert_drive_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_doe) |-> $past(bus_start));

    assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && bus_read) |-> !bus_doe);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !bus_doe);

    assert_hold_on_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_dout)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (req_ready && !rsp_done));

endmodule

bind ext_bus_master ebm_checker #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W)
) u_ebm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .bus_start (bus_start),
    .bus_doe   (bus_doe),
    .bus_read  (bus_read),
    .bus_ack   (bus_ack),
    .in_data   (in_data),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout)
);

// File: tb/ext_bus_master_tb.sv
// Bench for the external bus master: the bench plays arbiter and slave, with directed and seeded random transactions.
module ext_bus_master_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic [1:0]   req_burst = '0;
    logic [127:0] req_wdata = '0;
    logic         rsp_done;
    logic [127:0] rsp_rdata;
    logic         bus_req;
    logic         bus_grant = 1'b0;
    logic         bus_start;
    logic [31:0]  bus_addr;
    logic         bus_read;
    logic [1:0]   bus_size;
    logic [1:0]   bus_burst;
    logic [31:0]  bus_dout;
    logic         bus_doe;
    logic [31:0]  bus_din = '0;
    logic         bus_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_burst (req_burst),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .bus_req   (bus_req),
        .bus_grant (bus_grant),
        .bus_start (bus_start),
        .bus_addr  (bus_addr),
        .bus_read  (bus_read),
        .bus_size  (bus_size),
        .bus_burst (bus_burst),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .bus_din   (bus_din),
        .bus_ack   (bus_ack)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_log(input logic [1:0] burst, input logic [1:0] size);
        if (burst == 2'd1) return 2;
        if (burst == 2'd2) return 1;
        if (burst == 2'd3) return 0;
        return int'(size);
    endfunction

    function automatic int exp_beats(input logic [1:0] burst);
        if (burst == 2'd0) return 1;
        return 16 >> exp_log(burst, 2'd0);
    endfunction

    // Expected write word for beat k: low W bytes from the line, rest zero.
    function automatic logic [31:0] exp_word(input logic [127:0] line, input int k, input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < w; i++) r[8*i +: 8] = line[8*(k*w + i) +: 8];
        return r;
    endfunction

    task automatic run_txn(input bit wr, input logic [31:0] addr, input logic [1:0] size,
                           input logic [1:0] burst, input logic [127:0] wline,
                           input int gnt_wait, input int max_wait, input bit poke);
        int w = 1 << exp_log(burst, size);
        int nb = exp_beats(burst);
        logic [127:0] exp_line = '0;
        logic [31:0] word;
        check(req_ready == 1'b1, "R10", 128'(req_ready), 128'd1);
        req_write = wr; req_addr = addr; req_size = size; req_burst = burst; req_wdata = wline;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~wline;
        req_addr  = ~addr;
        check(bus_req == 1'b1 && bus_start == 1'b0, "R1", {bus_req, bus_start}, 128'b10);
        for (int g = 0; g < gnt_wait; g++) begin
            @(negedge clk);
            check(bus_req == 1'b1 && bus_start == 1'b0, "R1", {bus_req, bus_start}, 128'b10);
        end
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        check(bus_start == 1'b1, "R1", 128'(bus_start), 128'd1);
        check(bus_req == 1'b0, "R2", 128'(bus_req), 128'd0);
        check(bus_addr == addr && bus_read == !wr && bus_burst == burst && int'(bus_size) == exp_log(burst, size),
              "R3", {bus_addr, bus_read, bus_burst, bus_size}, {addr, !wr, burst, 2'(exp_log(burst, size))});
        check(bus_doe == 1'b0, "R6", 128'(bus_doe), 128'd0);
        for (int k = 0; k < nb; k++) begin
            int wt = $urandom_range(max_wait, 0);
            for (int c = 0; c <= wt; c++) begin
                @(negedge clk);
                bus_ack = 1'b0;
                if (poke && k == 0 && c == 0) begin
                    check(req_ready == 1'b0, "R11", 128'(req_ready), 128'd0);
                    req_valid = 1'b1;
                end else begin
                    req_valid = 1'b0;
                end
                check(bus_addr == addr + 32'(k*w), burst == 0 ? "R4" : "R5", 128'(bus_addr), 128'(addr + 32'(k*w)));
                check(bus_req == 1'b0 && bus_start == 1'b0, "R2", {bus_req, bus_start}, 128'd0);
                if (wr) begin
                    check(bus_doe == 1'b1 && bus_dout == exp_word(wline, k, w), c > 0 ? "R9" : "R6",
                          {bus_doe, bus_dout}, {1'b1, exp_word(wline, k, w)});
                end else begin
                    check(bus_doe == 1'b0, "R6", 128'(bus_doe), 128'd0);
                end
                if (c == wt) begin
                    word = $urandom;
                    bus_din = word;
                    bus_ack = 1'b1;
                    for (int i = 0; i < w; i++) exp_line[8*(k*w + i) +: 8] = word[8*i +: 8];
                end
            end
        end
        @(negedge clk);
        bus_ack = 1'b0;
        req_valid = 1'b0;
        bus_din = $urandom;
        check(rsp_done == 1'b1, "R10", 128'(rsp_done), 128'd1);
        check(bus_doe == 1'b0, "R7", 128'(bus_doe), 128'd0);
        if (!wr) check(rsp_rdata == exp_line, "R8", rsp_rdata, exp_line);
        @(negedge clk);
        check(rsp_done == 1'b0 && req_ready == 1'b1, "R10", {rsp_done, req_ready}, 128'b01);
        if (!wr) check(rsp_rdata == exp_line, "R10", rsp_rdata, exp_line);
        if (poke) begin
            @(negedge clk);
            check(bus_req == 1'b0 && bus_start == 1'b0, "R11", {bus_req, bus_start}, 128'd0);
        end
    endtask

    function automatic logic [127:0] rand_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && bus_req == 1'b0 && bus_start == 1'b0 && bus_doe == 1'b0 && rsp_done == 1'b0,
              "R10", {req_ready, bus_req, bus_start, bus_doe, rsp_done}, 128'b10000);
        // Directed: single transfers of each size (R4), both directions.
        for (int s = 0; s < 3; s++) begin
            run_txn(1'b1, 32'h1000_0000 + 32'(s*16), 2'(s), 2'd0, rand_line(), 0, 2, 1'b0);
            run_txn(1'b0, 32'h2000_0004, 2'(s), 2'd0, '0, 1, 2, 1'b0);
        end
        // Directed: each burst shape (R5), write then read, no waits then with waits.
        for (int b = 1; b < 4; b++) begin
            run_txn(1'b1, 32'h0000_1F00, 2'd3, 2'(b), rand_line(), 0, 0, 1'b0);
            run_txn(1'b0, 32'h0000_2F00, 2'd0, 2'(b), '0, 2, 3, 1'b0);
        end
        // Directed: request while busy is ignored (R11).
        run_txn(1'b0, 32'h0000_0040, 2'd2, 2'd1, '0, 0, 1, 1'b1);
        run_txn(1'b1, 32'h0000_0080, 2'd1, 2'd0, rand_line(), 0, 1, 1'b1);
        // Random mix.
        for (int n = 0; n < 40; n++) begin
            logic [1:0] bu = 2'($urandom_range(3, 0));
            logic [1:0] sz = 2'($urandom_range(2, 0));
            logic [31:0] ad = $urandom;
            run_txn(1'($urandom_range(1, 0)), ad, sz, bu, rand_line(),
                    $urandom_range(3, 0), 3, 1'($urandom_range(1, 0)));
        end
        finish_run();
    end

endmodule